// File: doc/BRIEF.md
# Transmit Descriptor Walker

This block steers the transmit side of a packet DMA engine. Software points it at a chain of transmit descriptors held in memory and raises a run bit. The block then reads each descriptor through a simple fetch port. It hands every descriptor that the DMA owns to the MAC transmit path as one frame. When the datapath reports the frame finished, the block writes the descriptor back to return it to software and follows the descriptor's link to the next one.

The block has three externally visible states: Stopped, Running and Suspended. It suspends on the first descriptor that software has not yet handed over, and it raises a sticky buffer-unavailable flag at that point. A poll strobe makes it look again. Clearing the run bit stops the block at the next frame boundary, or at once if it is suspended. The position it reached is kept, so a later run resumes from there instead of from the list base.

The fetch request, frame hand-off and write-back ports are valid/ready channels. Once valid is high, it and its payload stay unchanged until the cycle in which ready is sampled high, and the transfer happens in that cycle. The block holds its fetch-response ready high for every cycle in which it waits for a response. The run bit, poll, clear strobe, frame-done pulse and status outputs are plain signals.

Top module: `txdesc_dma_ctrl`

## Requirements
- R1: After reset, tx_state is 0 (Stopped), cur_desc_ptr is 0, stat_bu is 0, and no valid output is high.
- R2: When cfg_start is high in Stopped, tx_state becomes 1 (Running) on the next cycle and a fetch is requested at cur_desc_ptr. On the first start after reset, cur_desc_ptr is loaded from cfg_list_base. On later starts the saved position is kept. Each launched frame carries the fetched length.
- R3: A fetch response with dfetch_rsp_own low moves the block to tx_state 2 (Suspended) and sets stat_bu. No frame is launched, and cur_desc_ptr keeps that descriptor's address.
- R4: A start only takes effect from Stopped. While the block is Suspended with cfg_start held high, it issues no fetch without a poll, and cfg_list_base changes after the first start are never used.
- R5: With cfg_start low, Suspended becomes Stopped on the next cycle. Running becomes Stopped only after the frame in flight has completed and been written back.
- R6: After each write-back, cur_desc_ptr takes the next-descriptor address from that descriptor's fetch. This is the position kept across a stop, and frames follow the chain in link order.
- R7: After frame_done, one write-back is issued whose wb_desc_addr is the address of the frame just sent.
- R8: stat_bu stays set until a stat_bu_clr strobe clears it. If a set and a clear fall in the same cycle, the set wins.
- R9: In Suspended with cfg_start high, a poll_demand strobe re-fetches the current descriptor. If that descriptor is owned, the block returns to Running.
- R10: Each valid/ready output channel keeps valid and its payload stable until it is accepted, and at most one of the three is valid at a time.
- R11: A frame_done pulse while no frame is in flight has no effect on state or pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_list_base | input | AW | Address of the first descriptor, used on the first start |
| cfg_start | input | 1 | Run bit, level sensitive |
| poll_demand | input | 1 | Strobe: look again at the current descriptor while suspended |
| stat_bu_clr | input | 1 | Strobe: clear the buffer-unavailable flag |
| stat_bu | output | 1 | Sticky buffer-unavailable flag |
| tx_state | output | 2 | 0 Stopped, 1 Running, 2 Suspended |
| cur_desc_ptr | output | AW | Current descriptor position |
| dfetch_req_valid | output | 1 | Descriptor fetch request valid |
| dfetch_req_ready | input | 1 | Fetch request accepted |
| dfetch_req_addr | output | AW | Address of the descriptor to read |
| dfetch_rsp_valid | input | 1 | Fetch response valid |
| dfetch_rsp_ready | output | 1 | High while a response is awaited |
| dfetch_rsp_own | input | 1 | Descriptor is owned by the DMA |
| dfetch_rsp_len | input | LW | Buffer length of the descriptor |
| dfetch_rsp_next | input | AW | Address of the next descriptor |
| frm_valid | output | 1 | Frame hand-off valid |
| frm_ready | input | 1 | Transmit path takes the frame |
| frm_desc_addr | output | AW | Descriptor address of the frame |
| frm_len | output | LW | Frame length |
| frame_done | input | 1 | Pulse: transmit path finished the frame |
| wb_valid | output | 1 | Ownership write-back valid |
| wb_ready | input | 1 | Write-back accepted |
| wb_desc_addr | output | AW | Descriptor whose ownership is returned |

## Verification
The buffer-unavailable flag can be set by a non-owned fetch response in the same cycle that software strobes its clear. The bench provokes this by having its fetch responder raise the clear strobe on exactly the edge that returns a non-owned descriptor. It then requires the flag to read set afterwards. A second overlap is a stop request that lands while a frame is in flight. The bench drops the run bit right after the frame is accepted and checks that the block reports Running until the write-back completes, then Stopped at the linked descriptor, with no further frame launched.

// File: rtl/txd_pkg.sv
package txd_pkg;

  typedef enum logic [1:0] {
    TXS_STOPPED   = 2'd0,
    TXS_RUNNING   = 2'd1,
    TXS_SUSPENDED = 2'd2
  } txs_e;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_REQ    = 3'd1,
    PH_WAIT   = 3'd2,
    PH_LAUNCH = 3'd3,
    PH_XMIT   = 3'd4,
    PH_WB     = 3'd5,
    PH_SUSP   = 3'd6
  } ph_e;

  function automatic txs_e ph_to_txs(input ph_e p);
    case (p)
      PH_IDLE: return TXS_STOPPED;
      PH_SUSP: return TXS_SUSPENDED;
      default: return TXS_RUNNING;
    endcase
  endfunction

endpackage

// File: rtl/txd_ptr_track.sv
module txd_ptr_track #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] base,
  input  logic          start_go,
  input  logic          adv,
  input  logic [AW-1:0] adv_addr,
  output logic [AW-1:0] cur_ptr
);

  logic          used_q;
  logic [AW-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      used_q <= 1'b0;
      ptr_q  <= '0;
    end else begin
      if (start_go && !used_q) begin
        used_q <= 1'b1;
        ptr_q  <= base;
      end else if (adv) begin
        ptr_q  <= adv_addr;
      end
    end
  end

  assign cur_ptr = ptr_q;

endmodule

// File: rtl/txd_status.sv
module txd_status #(
  parameter int NFLAG = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] set,
  input  logic [NFLAG-1:0] clr,
  output logic [NFLAG-1:0] flag
);

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    logic f_q;
    always_ff @(posedge clk) begin
      if (!rst_n)      f_q <= 1'b0;
      else if (set[g]) f_q <= 1'b1;
      else if (clr[g]) f_q <= 1'b0;
    end
    assign flag[g] = f_q;
  end

endmodule

// File: rtl/txd_seq.sv
module txd_seq
  import txd_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_start,
  input  logic          poll,
  input  logic          frame_done,
  input  logic [AW-1:0] cur_ptr,
  output logic          req_valid,
  input  logic          req_ready,
  input  logic          rsp_valid,
  output logic          rsp_ready,
  input  logic          rsp_own,
  input  logic [LW-1:0] rsp_len,
  input  logic [AW-1:0] rsp_next,
  output logic          frm_valid,
  input  logic          frm_ready,
  output logic [LW-1:0] frm_len,
  output logic          wb_valid,
  input  logic          wb_ready,
  output logic          start_go,
  output logic          adv,
  output logic [AW-1:0] adv_addr,
  output logic          bu_set,
  output ph_e           phase
);

  ph_e           ph_q, ph_d;
  logic [LW-1:0] len_q;
  logic [AW-1:0] nxt_q;
  logic          cap;

  always_comb begin
    ph_d      = ph_q;
    req_valid = 1'b0;
    rsp_ready = 1'b0;
    frm_valid = 1'b0;
    wb_valid  = 1'b0;
    start_go  = 1'b0;
    adv       = 1'b0;
    bu_set    = 1'b0;
    cap       = 1'b0;
    case (ph_q)
      PH_IDLE: begin
        if (cfg_start) begin
          start_go = 1'b1;
          ph_d     = PH_REQ;
        end
      end
      PH_REQ: begin
        req_valid = 1'b1;
        if (req_ready) ph_d = PH_WAIT;
      end
      PH_WAIT: begin
        rsp_ready = 1'b1;
        if (rsp_valid) begin
          if (!rsp_own) begin
            bu_set = 1'b1;
            ph_d   = PH_SUSP;
          end else if (!cfg_start) begin
            ph_d = PH_IDLE;
          end else begin
            cap  = 1'b1;
            ph_d = PH_LAUNCH;
          end
        end
      end
      PH_LAUNCH: begin
        frm_valid = 1'b1;
        if (frm_ready) ph_d = PH_XMIT;
      end
      PH_XMIT: begin
        if (frame_done) ph_d = PH_WB;
      end
      PH_WB: begin
        wb_valid = 1'b1;
        if (wb_ready) begin
          adv  = 1'b1;
          ph_d = cfg_start ? PH_REQ : PH_IDLE;
        end
      end
      PH_SUSP: begin
        if (!cfg_start) ph_d = PH_IDLE;
        else if (poll)  ph_d = PH_REQ;
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      len_q <= '0;
      nxt_q <= '0;
    end else begin
      ph_q <= ph_d;
      if (cap) begin
        len_q <= rsp_len;
        nxt_q <= rsp_next;
      end
    end
  end

  assign frm_len  = len_q;
  assign adv_addr = nxt_q;
  assign phase    = ph_q;

  logic unused_ptr;
  assign unused_ptr = ^cur_ptr;

endmodule

// File: rtl/txdesc_dma_ctrl.sv
module txdesc_dma_ctrl
  import txd_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cfg_list_base,
  input  logic          cfg_start,
  input  logic          poll_demand,
  input  logic          stat_bu_clr,
  output logic          stat_bu,
  output logic [1:0]    tx_state,
  output logic [AW-1:0] cur_desc_ptr,
  output logic          dfetch_req_valid,
  input  logic          dfetch_req_ready,
  output logic [AW-1:0] dfetch_req_addr,
  input  logic          dfetch_rsp_valid,
  output logic          dfetch_rsp_ready,
  input  logic          dfetch_rsp_own,
  input  logic [LW-1:0] dfetch_rsp_len,
  input  logic [AW-1:0] dfetch_rsp_next,
  output logic          frm_valid,
  input  logic          frm_ready,
  output logic [AW-1:0] frm_desc_addr,
  output logic [LW-1:0] frm_len,
  input  logic          frame_done,
  output logic          wb_valid,
  input  logic          wb_ready,
  output logic [AW-1:0] wb_desc_addr
);

  logic          start_go, adv, bu_set;
  logic [AW-1:0] adv_addr, cur_ptr;
  ph_e           phase;
  logic [0:0]    flags;

  txd_ptr_track #(.AW(AW)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .base     (cfg_list_base),
    .start_go (start_go),
    .adv      (adv),
    .adv_addr (adv_addr),
    .cur_ptr  (cur_ptr)
  );

  txd_seq #(.AW(AW), .LW(LW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_start  (cfg_start),
    .poll       (poll_demand),
    .frame_done (frame_done),
    .cur_ptr    (cur_ptr),
    .req_valid  (dfetch_req_valid),
    .req_ready  (dfetch_req_ready),
    .rsp_valid  (dfetch_rsp_valid),
    .rsp_ready  (dfetch_rsp_ready),
    .rsp_own    (dfetch_rsp_own),
    .rsp_len    (dfetch_rsp_len),
    .rsp_next   (dfetch_rsp_next),
    .frm_valid  (frm_valid),
    .frm_ready  (frm_ready),
    .frm_len    (frm_len),
    .wb_valid   (wb_valid),
    .wb_ready   (wb_ready),
    .start_go   (start_go),
    .adv        (adv),
    .adv_addr   (adv_addr),
    .bu_set     (bu_set),
    .phase      (phase)
  );

  txd_status #(.NFLAG(1)) u_stat (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (bu_set),
    .clr   (stat_bu_clr),
    .flag  (flags)
  );

  assign stat_bu         = flags[0];
  assign tx_state        = ph_to_txs(phase);
  assign cur_desc_ptr    = cur_ptr;
  assign dfetch_req_addr = cur_ptr;
  assign frm_desc_addr   = cur_ptr;
  assign wb_desc_addr    = cur_ptr;

endmodule

// File: rtl/txd_chk.sv
module txd_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_start,
  input logic          stat_bu_clr,
  input logic          stat_bu,
  input logic [1:0]    tx_state,
  input logic [AW-1:0] cur_desc_ptr,
  input logic          dfetch_req_valid,
  input logic          dfetch_req_ready,
  input logic [AW-1:0] dfetch_req_addr,
  input logic          dfetch_rsp_valid,
  input logic          dfetch_rsp_ready,
  input logic          dfetch_rsp_own,
  input logic          frm_valid,
  input logic          frm_ready,
  input logic [AW-1:0] frm_desc_addr,
  input logic          wb_valid,
  input logic          wb_ready,
  input logic [AW-1:0] wb_desc_addr
);

  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> (tx_state == 2'd0 && cur_desc_ptr == '0 && !stat_bu));

  assert_start_runs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_state == 2'd0 && cfg_start) |=> tx_state == 2'd1);

  assert_unowned_suspends_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dfetch_rsp_valid && dfetch_rsp_ready && !dfetch_rsp_own) |=> (tx_state == 2'd2 && stat_bu));

  assert_susp_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_state == 2'd2 && !cfg_start) |=> tx_state == 2'd0);

  assert_wb_running_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> tx_state == 2'd1);

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_bu && !stat_bu_clr) |=> stat_bu);

  assert_fetch_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dfetch_req_valid && !dfetch_req_ready) |=> (dfetch_req_valid && $stable(dfetch_req_addr)));

  assert_frm_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && !frm_ready) |=> (frm_valid && $stable(frm_desc_addr)));

  assert_wb_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_desc_addr)));

  assert_one_channel_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dfetch_req_valid, frm_valid, wb_valid}));

endmodule

bind txdesc_dma_ctrl txd_chk #(.AW(AW)) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .cfg_start        (cfg_start),
  .stat_bu_clr      (stat_bu_clr),
  .stat_bu          (stat_bu),
  .tx_state         (tx_state),
  .cur_desc_ptr     (cur_desc_ptr),
  .dfetch_req_valid (dfetch_req_valid),
  .dfetch_req_ready (dfetch_req_ready),
  .dfetch_req_addr  (dfetch_req_addr),
  .dfetch_rsp_valid (dfetch_rsp_valid),
  .dfetch_rsp_ready (dfetch_rsp_ready),
  .dfetch_rsp_own   (dfetch_rsp_own),
  .frm_valid        (frm_valid),
  .frm_ready        (frm_ready),
  .frm_desc_addr    (frm_desc_addr),
  .wb_valid         (wb_valid),
  .wb_ready         (wb_ready),
  .wb_desc_addr     (wb_desc_addr)
);

// File: tb/tb_txdesc_dma_ctrl.sv
module tb_txdesc_dma_ctrl;
  localparam int AW = 32;
  localparam int LW = 14;
  localparam logic [31:0] BASE_A = 32'h0000_1000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] cfg_list_base = BASE_A;
  logic          cfg_start = 1'b0;
  logic          poll_demand = 1'b0;
  logic          main_clr = 1'b0, agent_clr = 1'b0;
  logic          stat_bu_clr;
  logic          stat_bu;
  logic [1:0]    tx_state;
  logic [AW-1:0] cur_desc_ptr;
  logic          dfetch_req_valid, dfetch_req_ready = 1'b0;
  logic [AW-1:0] dfetch_req_addr;
  logic          dfetch_rsp_valid = 1'b0, dfetch_rsp_ready, dfetch_rsp_own = 1'b0;
  logic [LW-1:0] dfetch_rsp_len = '0;
  logic [AW-1:0] dfetch_rsp_next = '0;
  logic          frm_valid, frm_ready = 1'b0;
  logic [AW-1:0] frm_desc_addr;
  logic [LW-1:0] frm_len;
  logic          main_fd = 1'b0, agent_fd = 1'b0;
  logic          frame_done;
  logic          wb_valid, wb_ready = 1'b0;
  logic [AW-1:0] wb_desc_addr;

  assign stat_bu_clr = main_clr | agent_clr;
  assign frame_done  = main_fd | agent_fd;

  always #2.5 clk = ~clk;

  txdesc_dma_ctrl #(.AW(AW), .LW(LW)) dut (.*);

  int total = 0, bad = 0;
  logic [15:0]   own_m;
  logic [LW-1:0] len_m [16];
  int            nxt_m [16];
  logic [31:0]   exp_q [$];
  int            exp_final;
  int            fetch_cnt = 0, rsp_cnt = 0, launch_cnt = 0;
  logic [31:0]   last_fetch = '0, last_frm = '0;
  logic          collide = 1'b0;

  function automatic logic [31:0] da(input int i);
    return BASE_A + 32'(i) * 32'd16;
  endfunction

  function automatic int ix(input logic [31:0] a);
    return int'(((a - BASE_A) >> 4) & 32'hF);
  endfunction

  function automatic void plan_walk(input int s);
    logic [15:0] o;
    int i;
    o = own_m;
    i = s;
    while (o[i]) begin
      exp_q.push_back(da(i));
      o[i] = 1'b0;
      i = nxt_m[i];
    end
    exp_final = i;
  endfunction

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", what, act, expv);
    end
  endtask

  task automatic wait_state(input logic [1:0] s, input string what);
    int n;
    n = 0;
    while (tx_state != s && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(tx_state == s, what, 32'(tx_state), 32'(s));
  endtask

  task automatic pulse_clr();
    main_clr = 1'b1;
    @(negedge clk);
    main_clr = 1'b0;
  endtask

  task automatic pulse_poll();
    poll_demand = 1'b1;
    @(negedge clk);
    poll_demand = 1'b0;
  endtask

  // descriptor fetch responder
  initial begin
    logic [31:0] fa;
    int fd, id;
    forever begin
      @(negedge clk);
      if (dfetch_req_valid) begin
        fa = dfetch_req_addr;
        fd = int'($urandom % 3);
        repeat (fd) begin
          @(negedge clk);
          chk(dfetch_req_valid && dfetch_req_addr == fa, "R10 fetch request held", dfetch_req_addr, fa);
        end
        dfetch_req_ready = 1'b1;
        @(negedge clk);
        dfetch_req_ready = 1'b0;
        fetch_cnt++;
        last_fetch = fa;
        fd = int'($urandom % 3);
        repeat (fd) @(negedge clk);
        id = ix(fa);
        dfetch_rsp_valid = 1'b1;
        dfetch_rsp_own   = own_m[id];
        dfetch_rsp_len   = len_m[id];
        dfetch_rsp_next  = da(nxt_m[id]);
        agent_clr        = collide;
        @(negedge clk);
        dfetch_rsp_valid = 1'b0;
        agent_clr = 1'b0;
        collide   = 1'b0;
        rsp_cnt++;
      end
    end
  end

  // transmit path model
  initial begin
    logic [31:0] fa, e;
    int fd;
    forever begin
      @(negedge clk);
      if (frm_valid) begin
        fa = frm_desc_addr;
        fd = int'($urandom % 3);
        repeat (fd) begin
          @(negedge clk);
          chk(frm_valid && frm_desc_addr == fa, "R10 frame hand-off held", frm_desc_addr, fa);
        end
        frm_ready = 1'b1;
        @(negedge clk);
        frm_ready = 1'b0;
        launch_cnt++;
        last_frm = fa;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6 unexpected frame", fa, 32'hFFFF_FFFF);
        end else begin
          e = exp_q.pop_front();
          chk(fa == e, "R6 frame follows chain", fa, e);
        end
        chk(frm_len == len_m[ix(fa)], "R2 frame length", 32'(frm_len), 32'(len_m[ix(fa)]));
        fd = 3 + int'($urandom % 4);
        repeat (fd) @(negedge clk);
        agent_fd = 1'b1;
        @(negedge clk);
        agent_fd = 1'b0;
      end
    end
  end

  // write-back sink
  initial begin
    int fd;
    forever begin
      @(negedge clk);
      if (wb_valid) begin
        fd = int'($urandom % 3);
        repeat (fd) @(negedge clk);
        chk(wb_desc_addr == last_frm, "R7 write-back address", wb_desc_addr, last_frm);
        wb_ready = 1'b1;
        @(negedge clk);
        wb_ready = 1'b0;
        own_m[ix(last_frm)] = 1'b0;
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int fc, lc, p;
    logic [31:0] pv;
    void'($urandom(32'd2024));
    own_m = '0;
    for (int i = 0; i < 16; i++) begin
      len_m[i] = LW'(1 + ($urandom % 1500));
      nxt_m[i] = (i + 1) % 16;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(tx_state == 2'd0, "R1 state after reset", 32'(tx_state), 0);
    chk(cur_desc_ptr == '0, "R1 pointer after reset", cur_desc_ptr, 0);
    chk(!stat_bu, "R1 flag after reset", 32'(stat_bu), 0);
    chk(!dfetch_req_valid && !frm_valid && !wb_valid, "R1 no valid after reset",
        32'({dfetch_req_valid, frm_valid, wb_valid}), 0);

    // R2/R3 first start, descriptor 0 not owned
    cfg_start = 1'b1;
    @(negedge clk);
    chk(tx_state == 2'd1, "R2 running after start", 32'(tx_state), 1);
    wait_state(2'd2, "R3 suspended on unowned");
    chk(last_fetch == da(0), "R2 first fetch at list base", last_fetch, da(0));
    chk(cur_desc_ptr == da(0), "R3 pointer stays on unowned", cur_desc_ptr, da(0));
    chk(stat_bu, "R3 flag set", 32'(stat_bu), 1);
    chk(launch_cnt == 0, "R3 no frame launched", 32'(launch_cnt), 0);

    // R4 held start does nothing while suspended; R11 stray frame_done
    fc = fetch_cnt;
    cfg_list_base = da(9);
    repeat (10) @(negedge clk);
    main_fd = 1'b1;
    @(negedge clk);
    main_fd = 1'b0;
    repeat (10) @(negedge clk);
    chk(fetch_cnt == fc, "R4 no fetch without poll", 32'(fetch_cnt), 32'(fc));
    chk(tx_state == 2'd2, "R11 state unchanged by stray done", 32'(tx_state), 2);
    chk(cur_desc_ptr == da(0), "R11 pointer unchanged by stray done", cur_desc_ptr, da(0));

    // R8 clear, then set and clear in the same cycle
    pulse_clr();
    chk(!stat_bu, "R8 flag cleared by strobe", 32'(stat_bu), 0);
    fc = rsp_cnt;
    collide = 1'b1;
    pulse_poll();
    while (rsp_cnt == fc) @(negedge clk);
    @(negedge clk);
    chk(fetch_cnt == fc + 1 || fetch_cnt > fc, "R9 poll re-fetches", 32'(fetch_cnt), 32'(fc + 1));
    chk(stat_bu, "R8 set wins over clear", 32'(stat_bu), 1);
    chk(tx_state == 2'd2, "R9 unowned stays suspended", 32'(tx_state), 2);

    // R9/R6/R7 poll after ownership handed over
    own_m[0] = 1'b1; own_m[1] = 1'b1; own_m[2] = 1'b1; own_m[3] = 1'b0;
    plan_walk(0);
    pulse_clr();
    pulse_poll();
    wait_state(2'd1, "R9 poll returns to running");
    wait_state(2'd2, "R3 suspend at end of chain");
    chk(exp_q.size() == 0, "R6 all chained frames sent", 32'(exp_q.size()), 0);
    chk(cur_desc_ptr == da(3), "R6 pointer follows links", cur_desc_ptr, da(3));
    chk(own_m[2:0] == 3'b000, "R7 write-backs returned descriptors", 32'(own_m[2:0]), 0);

    // R5 stop while suspended
    cfg_start = 1'b0;
    @(negedge clk);
    chk(tx_state == 2'd0, "R5 suspended stops at once", 32'(tx_state), 0);
    chk(cur_desc_ptr == da(3), "R6 position kept on stop", cur_desc_ptr, da(3));

    // R4/R6 restart resumes from saved position, not new base
    own_m[3] = 1'b1; nxt_m[3] = 4; own_m[4] = 1'b0;
    plan_walk(3);
    pulse_clr();
    cfg_start = 1'b1;
    @(negedge clk);
    wait_state(2'd2, "R6 resume run suspends");
    chk(exp_q.size() == 0, "R4 restart used saved position", 32'(exp_q.size()), 0);
    chk(cur_desc_ptr == da(4), "R6 pointer after resume", cur_desc_ptr, da(4));

    // R5 stop during a frame
    own_m[4] = 1'b1; nxt_m[4] = 5; own_m[5] = 1'b1; nxt_m[5] = 6; own_m[6] = 1'b0;
    exp_q.push_back(da(4));
    pulse_clr();
    lc = launch_cnt;
    pulse_poll();
    while (launch_cnt == lc) @(negedge clk);
    cfg_start = 1'b0;
    @(negedge clk);
    chk(tx_state == 2'd1, "R5 running until frame ends", 32'(tx_state), 1);
    wait_state(2'd0, "R5 stops after frame");
    chk(cur_desc_ptr == da(5), "R5 saved next descriptor", cur_desc_ptr, da(5));
    repeat (10) @(negedge clk);
    chk(launch_cnt == lc + 1, "R5 no frame after stop", 32'(launch_cnt), 32'(lc + 1));
    chk(own_m[5], "R5 next descriptor untouched", 32'(own_m[5]), 1);

    // random rounds
    p = 5;
    for (int r = 0; r < 12; r++) begin
      for (int i = 0; i < 16; i++) begin
        own_m[i] = ($urandom % 4) != 0;
        len_m[i] = LW'(1 + ($urandom % 2000));
        nxt_m[i] = int'($urandom % 16);
      end
      plan_walk(p);
      pulse_clr();
      cfg_start = 1'b1;
      @(negedge clk);
      wait_state(2'd2, "R3 random run suspends");
      pv = da(exp_final);
      chk(exp_q.size() == 0, "R6 random chain complete", 32'(exp_q.size()), 0);
      chk(cur_desc_ptr == pv, "R6 random final pointer", cur_desc_ptr, pv);
      chk(stat_bu, "R3 random flag set", 32'(stat_bu), 1);
      chk(last_fetch == pv, "R2 random last fetch", last_fetch, pv);
      cfg_start = 1'b0;
      @(negedge clk);
      chk(tx_state == 2'd0, "R5 random stop", 32'(tx_state), 0);
      exp_q.delete();
      p = exp_final;
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule